// File: doc/BRIEF.md
# eMMC Speed Mode and Receive Tune Control Register

This block is one 32-bit control word in a storage host controller. Software selects the bus speed mode through a 3-bit field and programs a 6-bit receive sampling-delay tap. The register decodes the mode into a set of select lines, exactly one of which is high.

A new tap value does not reach the receive path when the field is written. Software writes the tap together with a self-clearing update request bit. The hardware holds the request for a fixed two cycles and then clears it. On the clearing edge it moves the requested value into the applied-delay output. Software polls the request bit to learn when the new delay is in effect.

Only taps 0 to 42 are usable. A requested tap of 43 or more is applied as 0. The delay line itself and the card protocol sit outside this block.

Top module: `emmc_tune_ctrl`

## Requirements
- R1: A write stores wr_data bits 2:0 as the mode code, and rd_data bits 2:0 return it from the cycle after the write.
- R2: A write stores wr_data bits 13:8 as the tap field, and rd_data bits 13:8 return it unmodified, including values of 43 and above. rd_data bits 31:16, bit 14 and bits 7:3 always read 0.
- R3: A write with wr_data bit 15 = 1 makes rd_data bit 15 and busy read 1 from the next cycle.
- R4: The request bit clears by hardware exactly two clock edges after the edge that captured the request. A write with bit 15 = 0 neither sets nor clears a pending request.
- R5: applied_dly changes only on the edge where the request bit clears. It then takes the tap written together with that request. Writes with bit 15 = 0 leave applied_dly unchanged.
- R6: A requested tap of 43 to 63 is applied as 0. A requested tap of 0 to 42 is applied as written.
- R7: Mode decode is one-hot: code 2 selects sel_sdr, 3 selects sel_ddr, 4 selects sel_hs200, 5 selects sel_hs400, and codes 0, 1, 6 and 7 select sel_sd.
- R8: After reset, rd_data is 0, busy is 0, applied_dly is 0 and sel_sd is 1.
- R9: A new request written while one is pending restarts the two-edge wait. It replaces the staged tap, so the earlier tap is never applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register readback |
| busy | output | 1 | Tap update pending (mirror of bit 15) |
| applied_dly | output | 6 | Tap value in effect on the receive path |
| sel_sd | output | 1 | SD mode select (codes 0, 1, 6, 7) |
| sel_sdr | output | 1 | eMMC single data rate select |
| sel_ddr | output | 1 | eMMC dual data rate select |
| sel_hs200 | output | 1 | HS200 select |
| sel_hs400 | output | 1 | HS400 select |

## Verification
A sweep writes all eight mode codes, which separates each defined code from the reserved codes that must fall back to SD. A second sweep requests every tap from 0 to 63 and waits for each request to complete. It checks both the exact clearing cycle and the wrap point between 42 and 43. Writes with bit 15 low are then placed before and inside a pending window: they must change the readback but leave applied_dly and the pending state alone. Back-to-back requests show that the wait restarts and that only the last staged tap is applied. A behavioural model in the bench is compared against every output on every clock.

// File: rtl/emmc_tune_ctrl.sv
module emmc_tune_ctrl #(
  parameter int TUNE_W      = 6,
  parameter int TUNE_LIMIT  = 43,
  parameter int UPD_CYCLES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              busy,
  output logic [TUNE_W-1:0] applied_dly,
  output logic              sel_sd,
  output logic              sel_sdr,
  output logic              sel_ddr,
  output logic              sel_hs200,
  output logic              sel_hs400
);
  localparam int CW = (UPD_CYCLES > 2) ? $clog2(UPD_CYCLES) : 1;
  localparam logic [TUNE_W-1:0] LIM = TUNE_W'(TUNE_LIMIT);
  localparam logic [CW-1:0] RELOAD = CW'(UPD_CYCLES - 1);
  localparam int TLO = 8;
  localparam int THI = TLO + TUNE_W - 1;
  localparam int UPD = 15;

  logic [2:0]        mode_q;
  logic [TUNE_W-1:0] tune_q, stage_q, applied_q;
  logic              pend_q;
  logic [CW-1:0]     cnt_q;

  wire [TUNE_W-1:0] tune_in = wr_data[THI:TLO];
  wire              req     = wr_en & wr_data[UPD];
  wire              done    = pend_q & (cnt_q == '0) & ~req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      tune_q <= '0;
    end else if (wr_en) begin
      mode_q <= wr_data[2:0];
      tune_q <= tune_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      cnt_q     <= '0;
      stage_q   <= '0;
      applied_q <= '0;
    end else if (req) begin
      pend_q  <= 1'b1;
      cnt_q   <= RELOAD;
      stage_q <= (tune_in >= LIM) ? '0 : tune_in;
    end else if (done) begin
      pend_q    <= 1'b0;
      applied_q <= stage_q;
    end else if (pend_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[2:0]     = mode_q;
    rd_data[THI:TLO] = tune_q;
    rd_data[UPD]     = pend_q;
  end

  assign busy        = pend_q;
  assign applied_dly = applied_q;
  assign sel_sdr     = (mode_q == 3'd2);
  assign sel_ddr     = (mode_q == 3'd3);
  assign sel_hs200   = (mode_q == 3'd4);
  assign sel_hs400   = (mode_q == 3'd5);
  assign sel_sd      = ~(sel_sdr | sel_ddr | sel_hs200 | sel_hs400);

  // R3
  req_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> busy);

  // R4
  busy_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R5
  applied_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(applied_dly));

  // R6
  applied_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    applied_dly < LIM);

  // R7
  onehot_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_sd, sel_sdr, sel_ddr, sel_hs200, sel_hs400}) == 1);
endmodule

// File: tb/emmc_tune_ctrl_tb.sv
module emmc_tune_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        busy;
  logic [5:0]  applied_dly;
  logic        sel_sd, sel_sdr, sel_ddr, sel_hs200, sel_hs400;

  int checks = 0;
  int fails  = 0;
  bit live   = 0;
  bit ended  = 0;

  int m_mode = 0, m_tune = 0, m_left = 0, m_stage = 0, m_applied = 0;

  always #4 clk = ~clk;

  emmc_tune_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .applied_dly(applied_dly),
    .sel_sd(sel_sd), .sel_sdr(sel_sdr), .sel_ddr(sel_ddr),
    .sel_hs200(sel_hs200), .sel_hs400(sel_hs400)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_tune = 0; m_left = 0; m_stage = 0; m_applied = 0;
    end else begin
      if (wr_en && wr_data[15]) begin
        m_left  = 2;
        m_stage = (int'(wr_data[13:8]) > 42) ? 0 : int'(wr_data[13:8]);
      end else if (m_left > 0) begin
        m_left = m_left - 1;
      end
      if (m_left == 1 && !(wr_en && wr_data[15])) begin
        // handled next edge
      end
      if (m_left == 0 && !(wr_en && wr_data[15]) && m_stage_pending) begin
        m_applied = m_stage;
      end
      if (wr_en) begin
        m_mode = int'(wr_data[2:0]);
        m_tune = int'(wr_data[13:8]);
      end
    end
  end

  bit m_stage_pending;
  always @(posedge clk) m_stage_pending <= rst_n && ((wr_en && wr_data[15]) || (m_stage_pending && m_left != 0));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_sel(input int mode);
    case (mode)
      2: return 5'b01000;
      3: return 5'b00100;
      4: return 5'b00010;
      5: return 5'b00001;
      default: return 5'b10000;
    endcase
  endfunction

  always @(negedge clk) begin
    if (live) begin
      chk("R1", "mode readback", int'(rd_data[2:0]), m_mode);
      chk("R2", "tap readback", int'(rd_data[13:8]), m_tune);
      chk("R2", "unused bits", int'({rd_data[31:16], rd_data[14], rd_data[7:3]}), 0);
      chk("R3/R4 R9", "busy", int'(busy), int'(m_left > 0));
      chk("R4", "bit 15", int'(rd_data[15]), int'(m_left > 0));
      chk("R5 R6", "applied_dly", int'(applied_dly), m_applied);
      chk("R7", "mode selects", int'({sel_sd, sel_sdr, sel_ddr, sel_hs200, sel_hs400}), exp_sel(m_mode));
    end
  end

  task automatic wr(input int mode, input int tap, input bit upd);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = '0;
    wr_data[2:0]  = 3'(mode);
    wr_data[13:8] = 6'(tap);
    wr_data[15]   = upd;
    wr_data[31:16] = 16'hA5C3;
    wr_data[7:3]   = 5'h1F;
    wr_data[14]    = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", "rd_data in reset", int'(rd_data), 0);
    chk("R8", "applied in reset", int'(applied_dly), 0);
    chk("R8", "busy in reset", int'(busy), 0);
    chk("R8", "sel_sd in reset", int'(sel_sd), 1);
    rst_n = 1'b1;
    live  = 1;
    idle(2);
    // R1 R7 mode sweep
    for (int m = 0; m < 8; m++) begin
      wr(m, 0, 1'b0);
      idle(1);
    end
    // R3 R4 R5 R6 tap sweep with update
    for (int t = 0; t < 64; t++) begin
      wr(t % 8, t, 1'b1);
      idle(2);
    end
    // R5 write without update leaves applied tap
    wr(4, 17, 1'b1);
    idle(3);
    wr(4, 30, 1'b0);
    idle(3);
    // R4 bit 15 low inside a pending window
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_8000 | (32'd25 << 8) | 32'd3;
    @(negedge clk);
    wr_data = (32'd9 << 8) | 32'd5;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    idle(3);
    // R9 back-to-back requests restart the wait
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_8000 | (32'd11 << 8);
    @(negedge clk);
    wr_data = 32'h0000_8000 | (32'd37 << 8);
    @(negedge clk);
    wr_data = 32'h0000_8000 | (32'd50 << 8) | 32'd2;
    @(negedge clk);
    wr_data = 32'h0000_8000 | (32'd42 << 8) | 32'd2;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    idle(4);
    // R6 boundary 42 then 43
    wr(0, 42, 1'b1);
    idle(3);
    chk("R6", "tap 42 applied", int'(applied_dly), 42);
    wr(0, 43, 1'b1);
    idle(3);
    chk("R6", "tap 43 wraps", int'(applied_dly), 0);
    finish_run();
  end
endmodule